// File: doc/BRIEF.md
# Glitch-Free Oscillator Divider Switch

This block derives the system clock rate from a 32 MHz on-chip oscillator through a programmable power-of-two divider. The output is a single-cycle clock-enable pulse in the oscillator domain (`clk_tick`). Downstream logic that gates on this pulse runs at 32, 16, 8, 4, 2 or 1 MHz. Because the rate is carried by an enable, the output never produces a runt or a shortened period.

A write to the divider setting is checked before it is used. The block rejects a code that is not defined. It rejects a rate that is above the ceiling of the flash operating mode; that mode and a supply-range hint are static inputs. It also rejects a write made while clock-source rules forbid a change. When a write is accepted, the block hands over in a fixed sequence. Three further pulses are produced at the old rate. The divider then switches. Three pulses are produced at the new rate before the change counts as complete. A busy flag covers the whole hand-over, and an error flag records the most recent rejection.

Top module: `osc_div_switch`

## Requirements
- R1: After reset, the active code is 5 (1 MHz), `busy` and `err` are 0, and `clk_tick` pulses once every 32 oscillator cycles.
- R2: With active code c (0..5) and no hand-over in progress, `clk_tick` is high for one cycle in every 2^c oscillator cycles. Code 0 keeps it high on every cycle. Code c stands for 32/2^c MHz.
- R3: After an accepted write, `cur_code` keeps the old value for exactly 3 `clk_tick` pulses at the old rate. It then takes the written code.
- R4: `busy` rises in the cycle after an accepted write. It falls after 3 pulses at the new rate, so exactly 6 pulses occur while `busy` is high.
- R5: A write while `busy` is high is ignored. It does not change `cur_code`, the pending target or `err`.
- R6: A write is honoured when `src_hoco` = 1. When `src_hoco` = 0, a write is honoured only if `osc_stop` = 1; otherwise it is rejected.
- R7: Rate limits by `flash_mode` are as follows. 0 (low-voltage) accepts codes 3..5 (≤4 MHz). 1 (low-speed) accepts codes 2..5 (≤8 MHz). 2 (high-speed) accepts codes 1..5, and also code 0 when `hi_volt` = 1 (supply ≥ 2.7 V). 3 rejects every write.
- R8: Codes 6 and 7 are rejected.
- R9: A rejected write leaves `cur_code` unchanged, keeps `busy` at 0 and sets `err` in the next cycle. `err` stays set until the next accepted write, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | 32 MHz on-chip oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Divider write strobe |
| wr_code | input | 3 | Requested divider code |
| flash_mode | input | 2 | Static flash operating mode code |
| hi_volt | input | 1 | 1 when supply is at or above 2.7 V |
| src_hoco | input | 1 | 1 when the on-chip oscillator is the system clock source |
| osc_stop | input | 1 | Oscillator-stop control bit |
| clk_tick | output | 1 | Clock-enable pulse at the selected rate |
| cur_code | output | 3 | Divider code currently in force |
| busy | output | 1 | Hand-over in progress |
| err | output | 1 | Last write was rejected |

## Verification
The bench counts pulses across a hand-over. A design that switches too early shows fewer than three pulses at the old code. A design that ends the wait too soon shows fewer than six pulses under `busy`. It tries each flash-mode ceiling on both sides, including the high-speed mode with and without the supply hint. An off-by-one limit would accept a rate that is too fast or refuse one that is legal. Writes made during a hand-over must leave the target and the error flag alone. A rejected write must keep the old divider, which the bench confirms by measuring the pulse spacing afterwards.

// File: rtl/osc_div_switch.sv
module osc_div_switch #(
  parameter int MAX_CODE   = 5,
  parameter int HOLD_TICKS = 3,
  parameter int RST_CODE   = 5
) (
  input  logic       clk_osc,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_code,
  input  logic [1:0] flash_mode,
  input  logic       hi_volt,
  input  logic       src_hoco,
  input  logic       osc_stop,
  output logic       clk_tick,
  output logic [2:0] cur_code,
  output logic       busy,
  output logic       err
);
  localparam int CNT_W = MAX_CODE;
  localparam int HT_W  = $clog2(HOLD_TICKS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_OLD, ST_NEW} st_t;

  st_t             st;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       pend;
  logic [HT_W-1:0]  nt;
  logic [CNT_W:0]   lim;
  logic [2:0]       fastest;
  logic             mode_ok, accept, last_hold;

  assign lim       = ({{CNT_W{1'b0}}, 1'b1} << cur_code) - 1'b1;
  assign clk_tick  = (cnt == lim[CNT_W-1:0]);
  assign busy      = (st != ST_IDLE);
  assign last_hold = (nt == HT_W'(HOLD_TICKS - 1));

  always_comb begin
    mode_ok = 1'b1;
    case (flash_mode)
      2'd0:    fastest = 3'd3;
      2'd1:    fastest = 3'd2;
      2'd2:    fastest = hi_volt ? 3'd0 : 3'd1;
      default: begin fastest = 3'd7; mode_ok = 1'b0; end
    endcase
  end

  assign accept = mode_ok && (wr_code <= 3'(MAX_CODE)) && (wr_code >= fastest)
                  && (src_hoco || osc_stop);

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      pend     <= 3'(RST_CODE);
      cur_code <= 3'(RST_CODE);
      nt       <= '0;
      err      <= 1'b0;
    end else begin
      cnt <= clk_tick ? '0 : cnt + 1'b1;
      case (st)
        ST_IDLE: if (wr_en) begin
          if (accept) begin
            pend <= wr_code;
            st   <= ST_OLD;
            nt   <= '0;
            err  <= 1'b0;
          end else begin
            err  <= 1'b1;
          end
        end
        ST_OLD: if (clk_tick) begin
          if (last_hold) begin
            cur_code <= pend;
            nt       <= '0;
            st       <= ST_NEW;
          end else begin
            nt <= nt + 1'b1;
          end
        end
        default: if (clk_tick) begin
          if (last_hold) begin
            nt <= '0;
            st <= ST_IDLE;
          end else begin
            nt <= nt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

module osc_div_switch_chk (
  input logic       clk_osc,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_code,
  input logic       src_hoco,
  input logic       osc_stop,
  input logic       clk_tick,
  input logic [2:0] cur_code,
  input logic       busy,
  input logic       err
);
  AST_CODE_RANGE: assert property (@(posedge clk_osc) disable iff (!rst_n)
    cur_code <= 3'd5); // R8
  AST_DIV1_EVERY: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (cur_code == 3'd0) |-> clk_tick); // R2
  AST_CODE_ONLY_BUSY: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !$stable(cur_code) |-> $past(busy)); // R3
  AST_SWITCH_ON_TICK: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !$stable(cur_code) |-> $past(clk_tick)); // R3
  AST_BUSY_ERR_HOLD: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(err)); // R5
  AST_SRC_REJECT: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (!busy && wr_en && !src_hoco && !osc_stop) |=> (err && !busy)); // R6
  AST_BAD_CODE: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (!busy && wr_en && wr_code > 3'd5) |=> (err && $stable(cur_code))); // R9
  AST_BUSY_END_TICK: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $fell(busy) |-> $past(clk_tick)); // R4
endmodule

bind osc_div_switch osc_div_switch_chk u_chk (.*);

// File: tb/osc_div_switch_tb.sv
`timescale 1ns/1ps
module osc_div_switch_tb;
  logic clk_osc = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_code = 3'd0;
  logic [1:0] flash_mode = 2'd2;
  logic hi_volt = 1'b1, src_hoco = 1'b1, osc_stop = 1'b0;
  logic clk_tick, busy, err;
  logic [2:0] cur_code;

  int tests = 0, fails = 0;
  logic [2:0] exp_code = 3'd5;

  always #2.5 clk_osc = ~clk_osc;

  osc_div_switch u_dut (.*);

  // {mode[1:0], hi_volt, src_hoco, osc_stop, code[2:0], accept}
  localparam int NV = 14;
  localparam logic [8:0] VEC [NV] = '{
    {2'd2, 1'b1, 1'b1, 1'b0, 3'd0, 1'b1},
    {2'd2, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0},
    {2'd2, 1'b0, 1'b1, 1'b0, 3'd1, 1'b1},
    {2'd1, 1'b1, 1'b1, 1'b0, 3'd1, 1'b0},
    {2'd1, 1'b1, 1'b1, 1'b0, 3'd2, 1'b1},
    {2'd0, 1'b1, 1'b1, 1'b0, 3'd2, 1'b0},
    {2'd0, 1'b1, 1'b1, 1'b0, 3'd3, 1'b1},
    {2'd0, 1'b1, 1'b1, 1'b0, 3'd5, 1'b1},
    {2'd3, 1'b1, 1'b1, 1'b0, 3'd5, 1'b0},
    {2'd2, 1'b1, 1'b0, 1'b0, 3'd4, 1'b0},
    {2'd2, 1'b1, 1'b0, 1'b1, 3'd4, 1'b1},
    {2'd2, 1'b1, 1'b1, 1'b0, 3'd6, 1'b0},
    {2'd2, 1'b1, 1'b1, 1'b0, 3'd7, 1'b0},
    {2'd2, 1'b1, 1'b1, 1'b0, 3'd0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure_period(input string req, input int exp);
    int n = 0;
    while (!clk_tick) @(negedge clk_osc);
    @(negedge clk_osc); n = 1;
    while (!clk_tick && n < 100) begin @(negedge clk_osc); n++; end
    chk(req, n, exp);
  endtask

  task automatic write(input logic [2:0] c);
    wr_en = 1'b1; wr_code = c;
    @(negedge clk_osc);
    wr_en = 1'b0;
  endtask

  task automatic run_handover(input logic [2:0] oldc, output int old_ticks, output int all_ticks);
    int guard = 0;
    old_ticks = 0; all_ticks = 0;
    while (busy && guard < 2000) begin
      if (clk_tick) begin
        all_ticks++;
        if (cur_code == oldc) old_ticks++;
      end
      @(negedge clk_osc); guard++;
    end
  endtask

  initial begin
    @(negedge clk_osc); @(negedge clk_osc);
    chk("R1 reset code", cur_code, 5);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset err", err, 0);
    rst_n = 1'b1;
    measure_period("R1 reset period", 32);

    for (int i = 0; i < NV; i++) begin
      logic [8:0] v = VEC[i];
      int ot, at;
      flash_mode = v[8:7]; hi_volt = v[6]; src_hoco = v[5]; osc_stop = v[4];
      write(v[3:1]);
      if (v[0]) begin
        chk("R4 busy after accept", busy, 1);
        chk("R9 err cleared on accept", err, 0);
        run_handover(exp_code, ot, at);
        if (v[3:1] != exp_code) chk("R3 old-rate ticks", ot, 3);
        chk("R4 ticks during busy", at, 6);
        exp_code = v[3:1];
        chk("R3 new code", cur_code, exp_code);
        measure_period("R2 period", 1 << exp_code);
      end else begin
        chk(v[3:1] > 5 ? "R8 reject busy" : (v[5] ? "R7 reject busy" : "R6 reject busy"), busy, 0);
        chk("R9 err set", err, 1);
        chk("R9 code kept", cur_code, exp_code);
        measure_period("R9 rate kept", 1 << exp_code);
      end
    end

    // R5: write during hand-over is ignored
    flash_mode = 2'd2; hi_volt = 1'b1; src_hoco = 1'b1; osc_stop = 1'b0;
    write(3'd2);
    @(negedge clk_osc);
    write(3'd7);
    chk("R5 err unchanged", err, 0);
    write(3'd4);
    begin
      int ot, at;
      run_handover(exp_code, ot, at);
    end
    chk("R5 target kept", cur_code, 2);
    measure_period("R5 rate", 4);
    chk("R5 idle", busy, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_osc);
    fails++; tests++;
    $display("FAIL watchdog R4 actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule